// File: doc/BRIEF.md
# Pseudo-static RAM control and power-state decoder

This block is the clocked control core of a 4M x 16 pseudo-static RAM that presents an SRAM-style pin set. On every clock edge it samples the active-low chip enable, write enable, output enable, two byte enables and the sleep request. From these it picks one operating mode and drives the per-byte output enables of the data bus. It also keeps a small configuration register and the entry timer for the low-power states. A small behavioural word store with byte lanes stands in for the array, so that the bench can observe writes and reads.

A write cycle issued while the sleep request is held low does not touch the array. Instead it loads the configuration register from the low address bits. That register sets the page-mode enable, the refresh temperature code, the choice between partial-array retention and full power-off sleep, and the retained address window, which the block reports as a first/last address pair. The chosen low-power state takes effect only after the sleep request has been held for a fixed number of clock cycles, derived from the clock rate and a 10 us entry delay. If the request drops before then, the count starts again from zero. Once full power-off sleep has been in effect, a flag reports that the stored contents are no longer valid, and the next array write clears it.

There is no streaming data path, so the block has no valid/ready handshake and no back-pressure. All pins are plain level signals that are sampled every clock.

Top module: `psram_ctl_top`

## Requirements
- R1: The `op_mode` output encodes standby=0, write=1, read=2, active idle=3, register load=4, low-power=5, one cycle after the pins are sampled. With `ce_n`=1 and `zz_n`=1 the mode is standby, and `dq_oe` is 2'b00.
- R2: With `ce_n`=0, `zz_n`=1, `we_n`=0 and at least one byte enable low, the mode is write, and the enabled byte lanes of `wdata` are stored at word `addr[MEM_AW-1:0]`. `oe_n` has no effect, and `dq_oe` stays 2'b00.
- R3: With `ce_n`=0, `zz_n`=1, `we_n`=1, `oe_n`=0 and a byte enable low, the mode is read. On the next cycle `rdata` holds the stored word on the enabled lanes.
- R4: With the chip enabled and `zz_n`=1 but neither a read nor a write condition met (for example `oe_n`=1), the mode is active idle and `dq_oe` is 2'b00.
- R5: `dq_oe[0]` follows `lb_n` and covers bits 7:0, and `dq_oe[1]` follows `ub_n` and covers bits 15:8. A write changes only the enabled lanes.
- R6: With `ce_n`=0, `we_n`=0 and `zz_n`=0, the mode is register load. The register takes `addr[7]` as the page enable, `addr[6:5]` as the temperature code, `addr[4]` as the retention select (1 = partial retention, 0 = power-off) and `addr[2:0]` as the region code. The array is not written. The reset value is page off, temperature 2'b11, retention 1 and region 3'b000.
- R7: With `ce_n`=1 and `zz_n`=0, the mode is low-power. `par_active` (retention select 1) or `sleep_active` (retention select 0) rises after exactly ENTRY_CYC such consecutive cycles. Any cycle that breaks the condition restarts the count, and both outputs fall as soon as it is broken.
- R8: The region code maps to `keep_lo`/`keep_hi`/`keep_none` as follows. 111 gives 300000h-3FFFFFh, 110 gives 200000h-3FFFFFh and 101 gives 100000h-3FFFFFh. 100 gives `keep_none`=1. 011 gives 000000h-0FFFFFh, 010 gives 000000h-1FFFFFh, 001 gives 000000h-2FFFFFh and 000 gives 000000h-3FFFFFh.
- R9: `data_lost` sets on the edge after a cycle with `sleep_active`=1 and clears on the next array write. Partial retention does not set it.
- R10: `page_en` and `temp_code` show the stored register fields, and they change only on a register load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| ub_n | input | 1 | Upper byte enable, active low |
| lb_n | input | 1 | Lower byte enable, active low |
| zz_n | input | 1 | Sleep request, active low |
| addr | input | 22 | Word address, also the register load value |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid on lanes flagged by dq_oe |
| dq_oe | output | 2 | Per-byte data drive enable |
| op_mode | output | 3 | Decoded operating mode |
| page_en | output | 1 | Page mode enabled |
| temp_code | output | 2 | Refresh temperature code |
| par_active | output | 1 | Partial retention in effect |
| sleep_active | output | 1 | Power-off sleep in effect |
| keep_lo | output | 22 | First retained address |
| keep_hi | output | 22 | Last retained address |
| keep_none | output | 1 | No address retained |
| data_lost | output | 1 | Stored contents invalid after sleep |

## Verification
The bench counts the entry delay to its exact edge, one cycle short and then the cycle itself. A timer off by one would raise the low-power outputs a cycle early or a cycle late. It also interrupts the count partway and then waits one cycle short of the delay. A counter that only paused instead of restarting would enter the state too early. A register load is issued with write data present, and the same word is read back afterwards, which catches a decoder that lets the load slip through into the array. Single-lane writes and reads, and the full set of region codes including the none code and the wrap at the top of the address space, catch swapped byte lanes and region arithmetic that overflows.

// File: rtl/psram_ctl_pkg.sv
package psram_ctl_pkg;

  typedef enum logic [2:0] {
    OP_STANDBY = 3'd0,
    OP_WRITE   = 3'd1,
    OP_READ    = 3'd2,
    OP_IDLE    = 3'd3,
    OP_SETREG  = 3'd4,
    OP_SLEEP   = 3'd5
  } op_e;

  typedef struct packed {
    logic       page_on;
    logic [1:0] temp;
    logic       par_mode;
    logic [2:0] region;
  } mode_t;

  localparam mode_t MODE_RESET = '{page_on: 1'b0, temp: 2'b11, par_mode: 1'b1, region: 3'b000};

  function automatic op_e decode_pins(input logic ce_n, input logic we_n, input logic oe_n,
                                      input logic ub_n, input logic lb_n, input logic zz_n);
    logic any_byte;
    any_byte = !ub_n || !lb_n;
    if (ce_n)              return zz_n ? OP_STANDBY : OP_SLEEP;
    if (!zz_n)             return we_n ? OP_IDLE : OP_SETREG;
    if (!we_n)             return any_byte ? OP_WRITE : OP_IDLE;
    if (!oe_n && any_byte) return OP_READ;
    return OP_IDLE;
  endfunction

endpackage

// File: rtl/psram_cmd_decode.sv
module psram_cmd_decode
  import psram_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       we_n,
  input  logic       oe_n,
  input  logic       ub_n,
  input  logic       lb_n,
  input  logic       zz_n,
  output op_e        cmd,
  output logic [1:0] lane_sel,
  output logic [2:0] op_q
);

  assign cmd      = decode_pins(ce_n, we_n, oe_n, ub_n, lb_n, zz_n);
  assign lane_sel = {!ub_n, !lb_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) op_q <= 3'(OP_STANDBY);
    else        op_q <= 3'(cmd);
  end

endmodule

// File: rtl/psram_mode_reg.sv
module psram_mode_reg
  import psram_ctl_pkg::*;
#(
  parameter int AW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] addr,
  output mode_t         mode,
  output logic [AW-1:0] keep_lo,
  output logic [AW-1:0] keep_hi,
  output logic          keep_none
);

  localparam int QSH = AW - 2;

  logic [1:0]    k;
  logic [AW-1:0] top_lo;
  logic [AW-1:0] bot_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= MODE_RESET;
    else if (load) begin
      mode.page_on  <= addr[7];
      mode.temp     <= addr[6:5];
      mode.par_mode <= addr[4];
      mode.region   <= addr[2:0];
    end
  end

  assign k      = mode.region[1:0];
  assign top_lo = AW'(k) << QSH;
  assign bot_hi = (AW'(3'd4 - {1'b0, k}) << QSH) - AW'(1);

  always_comb begin
    keep_none = 1'b0;
    keep_lo   = '0;
    keep_hi   = '1;
    if (mode.region[2]) begin
      if (k == 2'b00) begin
        keep_none = 1'b1;
        keep_hi   = '0;
      end else begin
        keep_lo = top_lo;
      end
    end else begin
      keep_hi = bot_hi;
    end
  end

endmodule

// File: rtl/psram_lp_timer.sv
module psram_lp_timer #(
  parameter int ENTRY_CYC = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lp_req,
  input  logic par_mode,
  input  logic wr_stb,
  output logic par_on,
  output logic sleep_on,
  output logic data_lost
);

  localparam int CW = $clog2(ENTRY_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(ENTRY_CYC);

  logic [CW-1:0] cnt;
  logic          entered;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!lp_req)     cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + CW'(1);
  end

  assign entered  = (cnt == LIMIT);
  assign par_on   = entered && par_mode;
  assign sleep_on = entered && !par_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        data_lost <= 1'b0;
    else if (sleep_on) data_lost <= 1'b1;
    else if (wr_stb)   data_lost <= 1'b0;
  end

endmodule

// File: rtl/psram_word_store.sv
module psram_word_store #(
  parameter int NLANE  = 2,
  parameter int MEM_AW = 6
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [MEM_AW-1:0]  idx,
  input  logic [NLANE-1:0]   be,
  input  logic [8*NLANE-1:0] wdata,
  output logic [8*NLANE-1:0] rdata
);

  localparam int DEPTH = 1 << MEM_AW;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && be[g]) lane_mem[idx] <= wdata[8*g +: 8];
      if (rd_en && be[g]) rdata[8*g +: 8] <= lane_mem[idx];
    end
  end

endmodule

// File: rtl/psram_ctl_top.sv
module psram_ctl_top
  import psram_ctl_pkg::*;
#(
  parameter int AW        = 22,
  parameter int MEM_AW    = 6,
  parameter int CLK_MHZ   = 125,
  parameter int ENTRY_US  = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic          ub_n,
  input  logic          lb_n,
  input  logic          zz_n,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata,
  output logic [1:0]    dq_oe,
  output logic [2:0]    op_mode,
  output logic          page_en,
  output logic [1:0]    temp_code,
  output logic          par_active,
  output logic          sleep_active,
  output logic [AW-1:0] keep_lo,
  output logic [AW-1:0] keep_hi,
  output logic          keep_none,
  output logic          data_lost
);

  localparam int ENTRY_CYC = CLK_MHZ * ENTRY_US;
  localparam int NLANE     = 2;

  op_e        cmd;
  logic [1:0] lane_sel;
  mode_t      mode;

  psram_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .ub_n(ub_n), .lb_n(lb_n), .zz_n(zz_n),
    .cmd(cmd), .lane_sel(lane_sel), .op_q(op_mode)
  );

  psram_mode_reg #(.AW(AW)) u_mreg (
    .clk(clk), .rst_n(rst_n), .load(cmd == OP_SETREG), .addr(addr),
    .mode(mode), .keep_lo(keep_lo), .keep_hi(keep_hi), .keep_none(keep_none)
  );

  psram_lp_timer #(.ENTRY_CYC(ENTRY_CYC)) u_lp (
    .clk(clk), .rst_n(rst_n), .lp_req(cmd == OP_SLEEP), .par_mode(mode.par_mode),
    .wr_stb(cmd == OP_WRITE), .par_on(par_active), .sleep_on(sleep_active),
    .data_lost(data_lost)
  );

  psram_word_store #(.NLANE(NLANE), .MEM_AW(MEM_AW)) u_store (
    .clk(clk), .wr_en(cmd == OP_WRITE), .rd_en(cmd == OP_READ),
    .idx(addr[MEM_AW-1:0]), .be(lane_sel), .wdata(wdata), .rdata(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              dq_oe <= 2'b00;
    else if (cmd == OP_READ) dq_oe <= lane_sel;
    else                     dq_oe <= 2'b00;
  end

  assign page_en   = mode.page_on;
  assign temp_code = mode.temp;

endmodule

// File: rtl/psram_ctl_chk.sv
module psram_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] dq_oe,
  input logic [2:0] op_mode,
  input logic       page_en,
  input logic [1:0] temp_code,
  input logic       par_active,
  input logic       sleep_active,
  input logic       data_lost
);

  AST_IDLE_HIGHZ: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode != 3'd2) |-> (dq_oe == 2'b00)) else $error("idle drives bus"); // R1

  AST_READ_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode == 3'd2) |-> (dq_oe != 2'b00)) else $error("read with no lane"); // R5

  AST_LP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(par_active && sleep_active)) else $error("both low-power states"); // R7

  AST_LP_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (par_active || sleep_active) |-> (op_mode == 3'd5)) else $error("low-power outside request"); // R7

  AST_LOST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_lost) |-> $past(sleep_active)) else $error("loss flag without sleep"); // R9

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(page_en) || !$stable(temp_code)) |-> (op_mode == 3'd4)) else $error("config moved"); // R10

endmodule

bind psram_ctl_top psram_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dq_oe(dq_oe), .op_mode(op_mode), .page_en(page_en),
  .temp_code(temp_code), .par_active(par_active), .sleep_active(sleep_active),
  .data_lost(data_lost)
);

// File: tb/psram_ctl_top_test.sv
`timescale 1ns/1ps
module psram_ctl_top_test;

  localparam int ENTRY = 1250;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, ub_n = 1'b1, lb_n = 1'b1, zz_n = 1'b1;
  logic [21:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  dq_oe;
  logic [2:0]  op_mode;
  logic        page_en, par_active, sleep_active, keep_none, data_lost;
  logic [1:0]  temp_code;
  logic [21:0] keep_lo, keep_hi;

  always #4 clk = ~clk;

  psram_ctl_top uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .ub_n(ub_n),
    .lb_n(lb_n), .zz_n(zz_n), .addr(addr), .wdata(wdata), .rdata(rdata), .dq_oe(dq_oe),
    .op_mode(op_mode), .page_en(page_en), .temp_code(temp_code), .par_active(par_active),
    .sleep_active(sleep_active), .keep_lo(keep_lo), .keep_hi(keep_hi),
    .keep_none(keep_none), .data_lost(data_lost)
  );

  typedef struct {
    string       req;
    logic [2:0]  op;
    logic [1:0]  oe;
    logic [15:0] rd;
  } exp_t;

  exp_t exp_q[$];
  exp_t e;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  // monitor: one expected item per driven cycle, compared after the edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [15:0] m;
      e = exp_q.pop_front();
      m = {{8{e.oe[1]}}, {8{e.oe[0]}}};
      n_chk++;
      if (op_mode !== e.op || dq_oe !== e.oe || (rdata & m) !== (e.rd & m)) begin
        n_fail++;
        $display("FAIL %s: op=%0d oe=%b rd=%h expected op=%0d oe=%b rd=%h",
                 e.req, op_mode, dq_oe, rdata & m, e.op, e.oe, e.rd & m);
      end
    end
  end

  task automatic drv(input logic c, input logic w, input logic o, input logic u, input logic l,
                     input logic z, input logic [21:0] a, input logic [15:0] d,
                     input logic [2:0] eop, input logic [1:0] eoe, input logic [15:0] erd,
                     input string req);
    exp_t x;
    @(negedge clk);
    ce_n = c; we_n = w; oe_n = o; ub_n = u; lb_n = l; zz_n = z; addr = a; wdata = d;
    x.req = req; x.op = eop; x.oe = eoe; x.rd = erd;
    exp_q.push_back(x);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  // wait past the edge that follows the last drive
  task automatic settle();
    @(posedge clk); #2;
  endtask

  task automatic sleep_cycles(input int n, input string req);
    for (int i = 0; i < n; i++) drv(1, 1, 1, 1, 1, 0, 22'h0, 16'h0, 3'd5, 2'b00, 16'h0, req);
  endtask

  task automatic region(input logic [2:0] code, input logic [21:0] lo, input logic [21:0] hi,
                        input logic none);
    drv(0, 0, 1, 1, 1, 0, {19'h0, code} | 22'h10, 16'h0, 3'd4, 2'b00, 16'h0, "R6 load");
    settle();
    chk("R8 keep_lo", 32'(keep_lo), 32'(lo));
    chk("R8 keep_hi", 32'(keep_hi), 32'(hi));
    chk("R8 keep_none", 32'(keep_none), 32'(none));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R1 / R6 / R8 / R9 / R10 reset state
    chk("R1 reset op", 32'(op_mode), 32'd0);
    chk("R1 reset dq_oe", 32'(dq_oe), 32'd0);
    chk("R10 reset page_en", 32'(page_en), 32'd0);
    chk("R10 reset temp", 32'(temp_code), 32'd3);
    chk("R8 reset keep_hi", 32'(keep_hi), 32'h3FFFFF);
    chk("R9 reset lost", 32'(data_lost), 32'd0);

    // R2 / R5 writes, oe_n low ignored
    drv(0, 0, 0, 0, 0, 1, 22'd5, 16'hA5C3, 3'd1, 2'b00, 16'h0, "R2 write both");
    drv(0, 0, 1, 0, 0, 1, 22'd6, 16'h0000, 3'd1, 2'b00, 16'h0, "R2 clear");
    drv(0, 0, 1, 1, 0, 1, 22'd6, 16'hFF34, 3'd1, 2'b00, 16'h0, "R5 write low lane");
    drv(0, 0, 1, 0, 1, 1, 22'd6, 16'hAB99, 3'd1, 2'b00, 16'h0, "R5 write high lane");
    drv(0, 0, 1, 0, 0, 1, 22'd1, 16'h1111, 3'd1, 2'b00, 16'h0, "R2 write addr1");
    drv(0, 0, 1, 1, 1, 1, 22'd1, 16'hDEAD, 3'd3, 2'b00, 16'h0, "R4 write no lane");
    // R3 / R5 reads
    drv(0, 1, 0, 0, 0, 1, 22'd5, 16'h0, 3'd2, 2'b11, 16'hA5C3, "R3 read both");
    drv(0, 1, 0, 0, 0, 1, 22'd6, 16'h0, 3'd2, 2'b11, 16'hAB34, "R5 lanes merged");
    drv(0, 1, 0, 1, 0, 1, 22'd6, 16'h0, 3'd2, 2'b01, 16'h0034, "R5 read low");
    drv(0, 1, 0, 0, 1, 1, 22'd6, 16'h0, 3'd2, 2'b10, 16'hAB00, "R5 read high");
    drv(0, 1, 1, 0, 0, 1, 22'd5, 16'h0, 3'd3, 2'b00, 16'h0, "R4 oe high");
    drv(1, 1, 0, 0, 0, 1, 22'd5, 16'h0, 3'd0, 2'b00, 16'h0, "R1 standby");

    // R6 register load: page on, temp 00, power-off select, region 001; array untouched
    drv(0, 0, 1, 0, 0, 0, 22'h81, 16'hFFFF, 3'd4, 2'b00, 16'h0, "R6 load");
    drv(0, 1, 0, 0, 0, 1, 22'd1, 16'h0, 3'd2, 2'b11, 16'h1111, "R6 array untouched");
    settle();
    chk("R10 page_en", 32'(page_en), 32'd1);
    chk("R10 temp", 32'(temp_code), 32'd0);
    chk("R8 region 001 hi", 32'(keep_hi), 32'h2FFFFF);

    // R7 power-off sleep entry at exactly ENTRY cycles
    sleep_cycles(ENTRY - 1, "R7 pending");
    settle();
    chk("R7 early sleep", 32'(sleep_active), 32'd0);
    sleep_cycles(1, "R7 enter");
    settle();
    chk("R7 sleep on", 32'(sleep_active), 32'd1);
    chk("R7 no par", 32'(par_active), 32'd0);
    drv(1, 1, 1, 1, 1, 1, 22'h0, 16'h0, 3'd0, 2'b00, 16'h0, "R7 exit");
    settle();
    chk("R7 sleep off", 32'(sleep_active), 32'd0);
    chk("R9 lost set", 32'(data_lost), 32'd1);
    drv(0, 0, 1, 1, 0, 1, 22'd9, 16'h0042, 3'd1, 2'b00, 16'h0, "R9 write");
    settle();
    chk("R9 lost cleared", 32'(data_lost), 32'd0);

    // R7 restart after an interruption
    sleep_cycles(600, "R7 partial");
    drv(1, 1, 1, 1, 1, 1, 22'h0, 16'h0, 3'd0, 2'b00, 16'h0, "R7 break");
    sleep_cycles(ENTRY - 1, "R7 recount");
    settle();
    chk("R7 restart", 32'(sleep_active), 32'd0);

    // R6 / R7 partial retention: page off, temp 10, retention on, region 111
    drv(0, 0, 1, 1, 1, 0, 22'h57, 16'h0, 3'd4, 2'b00, 16'h0, "R6 load");
    settle();
    chk("R10 temp 10", 32'(temp_code), 32'd2);
    chk("R8 region 111 lo", 32'(keep_lo), 32'h300000);
    sleep_cycles(ENTRY, "R7 par");
    settle();
    chk("R7 par on", 32'(par_active), 32'd1);
    chk("R7 par no sleep", 32'(sleep_active), 32'd0);
    drv(1, 1, 1, 1, 1, 1, 22'h0, 16'h0, 3'd0, 2'b00, 16'h0, "R7 exit");
    settle();
    chk("R9 par keeps data", 32'(data_lost), 32'd0);
    chk("R7 par off", 32'(par_active), 32'd0);

    // R8 remaining region codes
    region(3'b110, 22'h200000, 22'h3FFFFF, 1'b0);
    region(3'b101, 22'h100000, 22'h3FFFFF, 1'b0);
    region(3'b100, 22'h000000, 22'h000000, 1'b1);
    region(3'b011, 22'h000000, 22'h0FFFFF, 1'b0);
    region(3'b010, 22'h000000, 22'h1FFFFF, 1'b0);
    region(3'b000, 22'h000000, 22'h3FFFFF, 1'b0);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule